// File: doc/BRIEF.md
# Latched Interrupt Request Controller

This block gathers the interrupt sources of a small 8-bit processor and turns them into one request line with a vector index. It handles two kinds of source. External sources are groups of input pins, each group with its own sensitivity setting and an edge latch. Peripheral sources are flags held in a status register and set by event pulses from their peripherals. Every source has an enable input, and one global mask bit blocks all requests while the processor is servicing one.

When the processor takes a request, it pulses the acknowledge input. This sets the global mask and clears the edge latch of the external source it took. A pulse on the return input clears the mask again. Software clears peripheral flags through a small register bus, in one of two ways. It can write zero to a flag's bit in the status register. It can also access the status register and then access that peripheral's data register. Either way, a request still waiting for its enable is discarded.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, every edge latch and peripheral flag reads 0, the global mask reads 1 and the request line is low.
- R2: Each external source reduces its pins to one level: the AND of its enabled pins, where a disabled pin counts as high. A 2-bit sensitivity code selects how this level is used: 01 rising, 10 falling, 11 either edge. In these edge modes the edge sets the source's latch, shown on `ext_pend`, one clock edge after the pin change. The latch stays set while the source is disabled or the global mask is set.
- R3: Sensitivity code 00 is level mode. The source requests for as long as the sampled level is low and keeps no memory of it. A low pin whose pin-enable is 0 has no effect.
- R4: In rising mode (01), a low sampled level blocks the source's latched request without clearing the latch. The request returns once the level is high again.
- R5: A peripheral event pulse sets its flag on the next clock edge; an event in the same cycle as a clear wins. A flag requests only when its enable is 1 and the global mask is 0; otherwise it stays pending.
- R6: A bus write to address 0 (the status register) clears every flag whose data bit is 0. Data bits of 1 leave their flags unchanged.
- R7: A status access, read or write, arms the clear sequence for each flag that is set at that moment. A later access to address 1+k (the data register of peripheral k) clears armed flag k. Any access to another address disarms all flags; cycles with no bus access keep them armed. A flag that is clear at the status access is not armed.
- R8: `irq_req` is high when some source requests and the mask is 0. `irq_vec` gives the lowest-numbered requesting source. External sources take indices 0 to NUM_EXT-1 and peripherals follow from NUM_EXT.
- R9: An acknowledge sets the global mask on the next edge and clears the latch of the external source named by `irq_vec`, unless a new edge arrives in the same cycle. An acknowledge never clears a peripheral flag.
- R10: A return pulse clears the global mask on the next edge. If an acknowledge arrives in the same cycle, the acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NUM_EXT*PINS_PER_SRC | External pins, grouped by source |
| ext_pin_en | input | NUM_EXT*PINS_PER_SRC | Per-pin enable into the group level |
| ext_sens | input | 2*NUM_EXT | Sensitivity code per external source |
| ext_en | input | NUM_EXT | Enable per external source |
| per_event | input | NUM_PER | Flag set pulses from peripherals |
| per_en | input | NUM_PER | Enable per peripheral flag |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Bus write when 1, read when 0 |
| bus_addr | input | AW | Bus address: 0 status, 1+k data register k |
| bus_wdata | input | NUM_PER | Bus write data |
| irq_ack | input | 1 | Processor accepts the request |
| irq_ret | input | 1 | Processor returns from service |
| irq_req | output | 1 | Combined interrupt request |
| irq_vec | output | VW | Index of the winning source |
| gmask | output | 1 | Global mask bit |
| ext_pend | output | NUM_EXT | Edge latches of external sources |
| per_flag | output | NUM_PER | Peripheral status flags |

## Verification
Every stored result (edge latches, flags, arming and the mask) changes on the first clock edge after the stimulus that causes it. `irq_req` and `irq_vec` follow that state within the same cycle and also follow the enable inputs directly. The bench drives inputs on the falling edge and advances its reference model on the following rising edge. It then compares every output on the next falling edge, before it changes any input, so each result is read in the first cycle it is due. The directed cases read the same ports one cycle after their stimulus, and they also confirm that state is retained while the source is blocked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        SENS_LOW  = 2'b00,
        SENS_RISE = 2'b01,
        SENS_FALL = 2'b10,
        SENS_BOTH = 2'b11
    } sens_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic edge_t find_edge(logic now_lvl, logic old_lvl);
        edge_t e;
        e.rise = now_lvl & ~old_lvl;
        e.fall = ~now_lvl & old_lvl;
        return e;
    endfunction

    function automatic logic edge_hits(sens_e mode, edge_t e);
        logic h;
        case (mode)
            SENS_RISE: h = e.rise;
            SENS_FALL: h = e.fall;
            SENS_BOTH: h = e.rise | e.fall;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/irqc_ext_src.sv
module irqc_ext_src
    import irqc_pkg::*;
#(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pins,
    input  logic [PINS-1:0] pin_en,
    input  logic [1:0]      sens,
    input  logic            en,
    input  logic            ack_here,
    output logic            pend,
    output logic            req
);
    logic  lvl;
    logic  samp;
    logic  lat;
    sens_e mode;
    edge_t edg;
    logic  hit;

    assign lvl  = &(pins | ~pin_en);
    assign mode = sens_e'(sens);
    assign edg  = find_edge(lvl, samp);
    assign hit  = edge_hits(mode, edg);

    always_ff @(posedge clk) begin
        if (rst) begin
            samp <= lvl;
            lat  <= 1'b0;
        end else begin
            samp <= lvl;
            if (hit)
                lat <= 1'b1;
            else if (ack_here)
                lat <= 1'b0;
        end
    end

    always_comb begin
        case (mode)
            SENS_LOW:  req = en & ~samp;
            SENS_RISE: req = en & lat & samp;
            default:   req = en & lat;
        endcase
    end

    assign pend = lat;

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        ack_here && (lvl == samp) |=> !pend);

    assert_latch_holds_R2: assert property (@(posedge clk) disable iff (rst)
        pend && !ack_here |=> pend);

    assert_low_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        mode == SENS_RISE && !lvl |=> (mode != SENS_RISE) || !req);

endmodule

// File: rtl/irqc_per_bank.sv
module irqc_per_bank #(
    parameter int NP = 3,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] set,
    input  logic [NP-1:0] en,
    input  logic          bus_en,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [NP-1:0] bus_wdata,
    output logic [NP-1:0] flag,
    output logic [NP-1:0] req
);
    logic          is_stat;
    logic [NP-1:0] is_data;
    logic [NP-1:0] arm;
    logic [NP-1:0] clr;

    assign is_stat = bus_en && (bus_addr == '0);

    for (genvar k = 0; k < NP; k++) begin : g_dec
        assign is_data[k] = bus_en && (bus_addr == AW'(k + 1));
        assign clr[k] = (is_stat && bus_we && !bus_wdata[k]) || (is_data[k] && arm[k]);

        assert_wr0_clears_R6: assert property (@(posedge clk) disable iff (rst)
            bus_en && bus_we && bus_addr == '0 && !bus_wdata[k] && !set[k] |=> !flag[k]);

        assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
            set[k] |=> flag[k]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= '0;
            arm  <= '0;
        end else begin
            flag <= set | (flag & ~clr);
            if (bus_en)
                arm <= is_stat ? flag : '0;
        end
    end

    assign req = flag & en;

    assert_other_disarms_R7: assert property (@(posedge clk) disable iff (rst)
        bus_en && bus_addr > AW'(NP) |=> arm == '0);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N  = 5,
    parameter int VW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  src_req,
    input  logic          ack,
    input  logic          ret,
    output logic          irq_req,
    output logic [VW-1:0] irq_vec,
    output logic [N-1:0]  grant,
    output logic          gmask
);
    logic [N-1:0] elig;

    assign elig    = src_req & {N{~gmask}};
    assign irq_req = |elig;

    always_comb begin
        irq_vec = '0;
        for (int i = N - 1; i >= 0; i--)
            if (elig[i]) irq_vec = VW'(i);
    end

    for (genvar i = 0; i < N; i++) begin : g_grant
        assign grant[i] = irq_req && (irq_vec == VW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst)      gmask <= 1'b1;
        else if (ack) gmask <= 1'b1;
        else if (ret) gmask <= 1'b0;
    end

    assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
        gmask |-> !irq_req);

    assert_lowest_wins_R8: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> src_req[irq_vec] && ((src_req & ((N'(1) << irq_vec) - N'(1))) == '0));

    assert_one_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    assert_ack_masks_R9: assert property (@(posedge clk) disable iff (rst)
        ack |=> gmask);

    assert_ret_unmasks_R10: assert property (@(posedge clk) disable iff (rst)
        ret && !ack |=> !gmask);

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
    parameter  int NUM_EXT      = 2,
    parameter  int PINS_PER_SRC = 2,
    parameter  int NUM_PER      = 3,
    localparam int NSRC = NUM_EXT + NUM_PER,
    localparam int AW   = $clog2(NUM_PER + 2),
    localparam int VW   = (NSRC > 1) ? $clog2(NSRC) : 1,
    localparam int NPIN = NUM_EXT * PINS_PER_SRC
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPIN-1:0]    ext_pin,
    input  logic [NPIN-1:0]    ext_pin_en,
    input  logic [2*NUM_EXT-1:0] ext_sens,
    input  logic [NUM_EXT-1:0] ext_en,
    input  logic [NUM_PER-1:0] per_event,
    input  logic [NUM_PER-1:0] per_en,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [NUM_PER-1:0] bus_wdata,
    input  logic               irq_ack,
    input  logic               irq_ret,
    output logic               irq_req,
    output logic [VW-1:0]      irq_vec,
    output logic               gmask,
    output logic [NUM_EXT-1:0] ext_pend,
    output logic [NUM_PER-1:0] per_flag
);
    logic [NUM_EXT-1:0] ext_req;
    logic [NUM_PER-1:0] per_req;
    logic [NSRC-1:0]    grant;

    for (genvar k = 0; k < NUM_EXT; k++) begin : g_ext
        irqc_ext_src #(.PINS(PINS_PER_SRC)) u_src (
            .clk      (clk),
            .rst      (rst),
            .pins     (ext_pin[k*PINS_PER_SRC +: PINS_PER_SRC]),
            .pin_en   (ext_pin_en[k*PINS_PER_SRC +: PINS_PER_SRC]),
            .sens     (ext_sens[2*k +: 2]),
            .en       (ext_en[k]),
            .ack_here (irq_ack & grant[k]),
            .pend     (ext_pend[k]),
            .req      (ext_req[k])
        );
    end

    irqc_per_bank #(.NP(NUM_PER), .AW(AW)) u_per (
        .clk       (clk),
        .rst       (rst),
        .set       (per_event),
        .en        (per_en),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flag      (per_flag),
        .req       (per_req)
    );

    irqc_arbiter #(.N(NSRC), .VW(VW)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .src_req ({per_req, ext_req}),
        .ack     (irq_ack),
        .ret     (irq_ret),
        .irq_req (irq_req),
        .irq_vec (irq_vec),
        .grant   (grant),
        .gmask   (gmask)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> gmask && ext_pend == '0 && per_flag == '0 && !irq_req);

endmodule

// File: tb/test_irq_latch_ctrl.sv
`timescale 1ns/1ps
module test_irq_latch_ctrl;
    localparam int NE = 2, PS = 2, NP = 3;
    localparam int N = NE + NP, AW = 3, VW = 3;

    logic clk = 1'b0, rst = 1'b1;
    logic [NE*PS-1:0] ext_pin = '1, ext_pin_en = '1;
    logic [2*NE-1:0] ext_sens = '0;
    logic [NE-1:0] ext_en = '0;
    logic [NP-1:0] per_event = '0, per_en = '0, bus_wdata = '0;
    logic bus_en = 0, bus_we = 0, irq_ack = 0, irq_ret = 0;
    logic [AW-1:0] bus_addr = '0;
    logic irq_req, gmask;
    logic [VW-1:0] irq_vec;
    logic [NE-1:0] ext_pend;
    logic [NP-1:0] per_flag;

    irq_latch_ctrl i_irq_latch_ctrl (.*);

    always #4 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [NE-1:0] m_samp, m_lat;
    logic [NP-1:0] m_flag, m_arm;
    logic m_g;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic lvl(int k);
        return &(ext_pin[k*PS +: PS] | ~ext_pin_en[k*PS +: PS]);
    endfunction

    function automatic logic [N-1:0] m_src();
        logic [N-1:0] s;
        for (int k = 0; k < NE; k++) begin
            case (ext_sens[2*k +: 2])
                2'b00:   s[k] = ~m_samp[k];
                2'b01:   s[k] = m_lat[k] & m_samp[k];
                default: s[k] = m_lat[k];
            endcase
            s[k] = s[k] & ext_en[k];
        end
        s[N-1:NE] = m_flag & per_en;
        return s;
    endfunction

    function automatic logic m_req();
        return !m_g && (m_src() != '0);
    endfunction

    function automatic int m_vec();
        logic [N-1:0] s = m_src();
        for (int i = 0; i < N; i++) if (s[i]) return i;
        return 0;
    endfunction

    task automatic model_step();
        logic r = m_req();
        int v = m_vec();
        logic [NP-1:0] old_flag = m_flag;
        for (int k = 0; k < NE; k++) begin
            logic c = lvl(k);
            logic rise = c & ~m_samp[k], fall = ~c & m_samp[k];
            logic hit;
            case (ext_sens[2*k +: 2])
                2'b01:   hit = rise;
                2'b10:   hit = fall;
                2'b11:   hit = rise | fall;
                default: hit = 1'b0;
            endcase
            if (hit) m_lat[k] = 1'b1;
            else if (irq_ack && r && v == k) m_lat[k] = 1'b0;
            m_samp[k] = c;
        end
        for (int k = 0; k < NP; k++) begin
            logic clr = bus_en && ((bus_addr == 0 && bus_we && !bus_wdata[k]) ||
                                   (bus_addr == AW'(k + 1) && m_arm[k]));
            m_flag[k] = per_event[k] | (old_flag[k] & ~clr);
        end
        if (bus_en) m_arm = (bus_addr == 0) ? old_flag : '0;
        if (irq_ack) m_g = 1'b1;
        else if (irq_ret) m_g = 1'b0;
    endtask

    task automatic compare_all();
        chk(cur_tag, "irq_req", irq_req, m_req());
        chk(cur_tag, "gmask", gmask, m_g);
        chk(cur_tag, "ext_pend", ext_pend, m_lat);
        chk(cur_tag, "per_flag", per_flag, m_flag);
        if (m_req()) chk(cur_tag, "irq_vec", irq_vec, m_vec());
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic bus_op(logic we, int addr, int wd);
        bus_en = 1; bus_we = we; bus_addr = AW'(addr); bus_wdata = NP'(wd);
        tick();
        bus_en = 0; bus_we = 0;
    endtask

    task automatic pulse_ack();
        irq_ack = 1; tick(); irq_ack = 0;
    endtask

    task automatic pulse_ret();
        irq_ret = 1; tick(); irq_ret = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        m_lat = '0; m_flag = '0; m_arm = '0; m_g = 1'b1;
        for (int k = 0; k < NE; k++) m_samp[k] = lvl(k);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk("R1", "gmask", gmask, 1);
        chk("R1", "irq_req", irq_req, 0);
        chk("R1", "ext_pend", ext_pend, 0);
        chk("R1", "per_flag", per_flag, 0);

        // R2 rising edge latches while source disabled and mask set
        cur_tag = "R2";
        ext_sens = 4'b0001;
        ext_pin[0] = 0; tick();
        chk("R2", "pend after fall in rise mode", ext_pend[0], 0);
        ext_pin[0] = 1; tick();
        chk("R2", "pend after rise", ext_pend[0], 1);
        chk("R2", "req while masked", irq_req, 0);
        cur_tag = "R10";
        pulse_ret();
        chk("R10", "gmask after ret", gmask, 0);
        chk("R2", "req while disabled", irq_req, 0);
        chk("R2", "pend retained", ext_pend[0], 1);
        ext_en[0] = 1; #1;
        chk("R2", "req once enabled", irq_req, 1);
        chk("R8", "vec", irq_vec, 0);

        // R4 low level blocks rise-mode request, latch kept
        cur_tag = "R4";
        ext_pin[1] = 0; tick();
        chk("R4", "req blocked by low", irq_req, 0);
        chk("R4", "pend kept", ext_pend[0], 1);
        ext_pin[1] = 1; tick();
        chk("R4", "req back", irq_req, 1);

        // R9 ack sets mask, clears latch
        cur_tag = "R9";
        pulse_ack();
        chk("R9", "gmask after ack", gmask, 1);
        chk("R9", "pend cleared", ext_pend[0], 0);
        // R10 ack beats ret
        cur_tag = "R10";
        irq_ret = 1; irq_ack = 1; tick(); irq_ret = 0; irq_ack = 0;
        chk("R10", "ack wins", gmask, 1);
        pulse_ret();

        // R3 level mode on source 1
        cur_tag = "R3";
        ext_sens = 4'b0001; ext_en = 2'b10;
        ext_pin_en[3] = 0; ext_pin[3] = 0; tick();
        chk("R3", "disabled pin low", irq_req, 0);
        ext_pin[2] = 0; tick();
        chk("R3", "req low level", irq_req, 1);
        chk("R3", "vec", irq_vec, 1);
        ext_pin[2] = 1; tick();
        chk("R3", "req drops", irq_req, 0);
        ext_pin_en[3] = 1; ext_pin[3] = 1; tick();

        // R5 peripheral flag pending until enabled
        cur_tag = "R5";
        per_event[0] = 1; tick(); per_event[0] = 0;
        chk("R5", "flag set", per_flag[0], 1);
        chk("R5", "req while disabled", irq_req, 0);
        per_en[0] = 1; #1;
        chk("R5", "req enabled", irq_req, 1);
        chk("R8", "per vec", irq_vec, NE);
        // R8 external beats peripheral
        cur_tag = "R8";
        ext_sens = 4'b0011; ext_en = 2'b01;
        ext_pin[0] = 0; tick();
        chk("R8", "ext wins", irq_vec, 0);
        cur_tag = "R9";
        pulse_ack();
        chk("R9", "flag untouched by ack", per_flag[0], 1);
        chk("R9", "both-edge latch cleared", ext_pend[0], 0);
        ext_pin[0] = 1; tick();
        pulse_ret();

        // R6 write zero clears, write one keeps
        cur_tag = "R6";
        per_event = 3'b110; tick(); per_event = 0;
        bus_op(1, 0, 3'b111);
        chk("R6", "write ones keep", per_flag, 3'b111);
        bus_op(1, 0, 3'b101);
        chk("R6", "write zero clears", per_flag, 3'b101);

        // R7 two-step clear
        cur_tag = "R7";
        per_en = 0;
        bus_op(0, 0, 0); tick();
        bus_op(0, 1, 0);
        chk("R7", "seq clears", per_flag[0], 0);
        bus_op(0, 0, 0);
        bus_op(0, 7, 0);
        bus_op(0, 3, 0);
        chk("R7", "other access disarms", per_flag[2], 1);
        bus_op(0, 0, 0);
        per_event[1] = 1; tick(); per_event[1] = 0;
        bus_op(0, 2, 0);
        chk("R7", "clear flag not armed", per_flag[1], 1);

        // Random phase
        cur_tag = "R2 R5 R7 R8 random";
        void'($urandom(32'h1bad5eed));
        for (int c = 0; c < 4000; c++) begin
            for (int b = 0; b < NE*PS; b++) if ($urandom_range(7) == 0) ext_pin[b] = ~ext_pin[b];
            if ($urandom_range(31) == 0) ext_pin_en = NE*PS'($urandom);
            if ($urandom_range(63) == 0) ext_sens = 2*NE'($urandom);
            if ($urandom_range(15) == 0) ext_en = NE'($urandom);
            if ($urandom_range(15) == 0) per_en = NP'($urandom);
            per_event = ($urandom_range(5) == 0) ? NP'($urandom) : '0;
            bus_en = ($urandom_range(3) == 0);
            bus_we = $urandom_range(1);
            bus_addr = ($urandom_range(1) == 0) ? AW'(0) : AW'($urandom);
            bus_wdata = NP'($urandom) | NP'($urandom);
            irq_ack = m_req() && ($urandom_range(2) == 0);
            irq_ret = ($urandom_range(5) == 0);
            tick();
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule